// File: doc/BRIEF.md
# Seven-to-one LVDS receive deserializer with word alignment

This block sits behind the input DDR capture registers of a seven-bit-per-word source-synchronous LVDS receiver. Every fast-clock cycle it takes two serial bits from each of the data lanes and two bits from the sampled forwarded-clock lane. The fast clock runs at three and a half times the word rate, so a word spans three or four fast cycles and often straddles a cycle boundary. The block rebuilds seven-bit words and presents them as one wide parallel word, 28 bits for four lanes or 21 bits for three.

The word boundary comes from the clock lane. A correctly framed clock-lane slice reads `1100011`, earliest bit first. Its rising transition therefore falls two bit times before the boundary. The block first searches every bit offset for that shape. It then confirms the shape at one offset over several words and locks. Once locked, it cuts every data lane at that offset, which acts as a bit slip. If the shape keeps failing, it drops lock and searches again.

Top module: `deser7_rx`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `locked` and `word_vld` are 0 and `word_out` is all zeros.
- R2: `locked` rises one clock edge after the fast cycle that completes the fourth consecutive word whose clock-lane slice equals `1100011` at one offset. The word that completes the lock is itself output.
- R3: `word_vld` is high for exactly one cycle per assembled word and only while `locked` is high. Successive pulses during an unbroken lock are spaced alternately 4 and 3 cycles apart.
- R4: In each input pair, bit 1 is the earlier serial bit. Each lane's seven bits are assembled earliest bit first into the MSB. Lane i occupies `word_out[7i+6:7i]`, with lane i's pair on `data_lane_bits[2i+1:2i]`. The word boundary is the one at which the clock-lane slice reads `1100011`.
- R5: While locked, a single word whose clock-lane slice mismatches keeps lock, and that word is still output. Two consecutive mismatching words drop `locked`, with no pulse on `word_vld` for the second one, and the search restarts.
- R6: While `locked` is low, `word_vld` stays 0 and `word_out` holds its last value.
- R7: Alignment and output are correct for all seven bit offsets of the word boundary relative to the pair boundary. This includes words that end on either bit of a pair.
- R8: During confirmation, before lock, one mismatching clock-lane word restarts the search. Lock then needs four fresh consecutive matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast capture clock, 3.5x the word rate |
| rst | input | 1 | Synchronous active-high reset |
| clk_lane_bits | input | 2 | Sampled forwarded-clock bits, bit 1 earlier |
| data_lane_bits | input | 2*LANES | Two serial bits per data lane, lane i at [2i+1:2i], bit 2i+1 earlier |
| word_out | output | 7*LANES | Aligned parallel word, lane i at [7i+6:7i] |
| word_vld | output | 1 | One-cycle strobe per assembled word |
| locked | output | 1 | Word alignment is established |

## Verification
Every result is due one clock edge after the fast cycle whose bit pair completes the word. That holds for the output word, its strobe, and a rise or fall of `locked`; nothing is pipelined further. The bench drives the pair for cycle t at a falling edge and records the expected strobe, lock flag and held word for that cycle in a queue. At the next falling edge, after the single rising edge in between, it pops that entry and compares. The expectation comes from a bit-stream model of the framing and lock rules. A separate check measures the spacing between strobes to confirm the 4/3 cadence.

// File: rtl/lvds7_pkg.sv
package lvds7_pkg;
  localparam int WORD_BITS = 7;
  // Forwarded-clock shape over one word, earliest bit in the MSB
  localparam logic [WORD_BITS-1:0] CLK_SHAPE = 7'b1100011;

  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCK    = 2'd2
  } align_st_t;
endpackage

// File: rtl/deser7_gearbox.sv
// Per-lane 2-bit to word gearbox: keeps the last WORD+1 serial bits and
// offers the two word-sized slices that can end in the current cycle.
module deser7_gearbox #(
  parameter int WORD = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      pair,
  output logic [WORD-1:0] slice_late,
  output logic [WORD-1:0] slice_early
);
  logic [WORD-2:0] hist;
  logic [WORD:0]   nwin;

  // newest bit lands in bit 0, so the oldest bit of a slice is its MSB
  assign nwin = {hist, pair};

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= nwin[WORD-2:0];
  end

  assign slice_late  = nwin[WORD-1:0];
  assign slice_early = nwin[WORD:1];
endmodule

// File: rtl/deser7_phase.sv
// Counts received bits modulo WORD; gives the count after this cycle's
// pair and the count one bit earlier.
module deser7_phase #(
  parameter int WORD = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  output logic [$clog2(WORD)-1:0]  ncnt,
  output logic [$clog2(WORD)-1:0]  nprev
);
  localparam int CW = $clog2(WORD);
  logic [CW-1:0] cnt;

  always_comb begin
    if (cnt >= CW'(WORD - 2)) ncnt = cnt - CW'(WORD - 2);
    else                      ncnt = cnt + CW'(2);
    if (ncnt == '0) nprev = CW'(WORD - 1);
    else            nprev = ncnt - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= ncnt;
  end
endmodule

// File: rtl/deser7_align.sv
// Boundary search, confirmation, lock and loss-of-lock on the clock lane.
module deser7_align import lvds7_pkg::*; #(
  parameter int              WORD       = 7,
  parameter int              LOCK_WORDS = 4,
  parameter int              MISS_WORDS = 2,
  parameter logic [WORD-1:0] SHAPE      = CLK_SHAPE
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(WORD)-1:0] ncnt,
  input  logic [$clog2(WORD)-1:0] nprev,
  input  logic [WORD-1:0]         clk_late,
  input  logic [WORD-1:0]         clk_early,
  output logic                    pick_early,
  output logic                    emit,
  output logic                    locked
);
  localparam int CW = $clog2(WORD);
  localparam int HW = $clog2(LOCK_WORDS + 1);
  localparam int MW = $clog2(MISS_WORDS + 1);

  align_st_t     st, st_n;
  logic [CW-1:0] off, off_n;
  logic [HW-1:0] hits, hits_n;
  logic [MW-1:0] miss, miss_n;
  logic          ev_late, ev_early, ev, hit;
  logic          lock_q;

  assign ev_late    = (st != ST_SEARCH) && (ncnt  == off);
  assign ev_early   = (st != ST_SEARCH) && (nprev == off);
  assign ev         = ev_late || ev_early;
  assign hit        = (ev_early ? clk_early : clk_late) == SHAPE;
  assign pick_early = ev_early;

  always_comb begin
    st_n   = st;
    off_n  = off;
    hits_n = hits;
    miss_n = miss;
    unique case (st)
      ST_SEARCH: begin
        if (clk_late == SHAPE) begin
          off_n  = ncnt;
          st_n   = ST_CONFIRM;
          hits_n = HW'(1);
        end else if (clk_early == SHAPE) begin
          off_n  = nprev;
          st_n   = ST_CONFIRM;
          hits_n = HW'(1);
        end
      end
      ST_CONFIRM: begin
        if (ev) begin
          if (!hit) begin
            st_n   = ST_SEARCH;
            hits_n = '0;
          end else if (hits == HW'(LOCK_WORDS - 1)) begin
            st_n   = ST_LOCK;
            miss_n = '0;
          end else begin
            hits_n = hits + HW'(1);
          end
        end
      end
      ST_LOCK: begin
        if (ev) begin
          if (hit) begin
            miss_n = '0;
          end else if (miss == MW'(MISS_WORDS - 1)) begin
            st_n   = ST_SEARCH;
            hits_n = '0;
            miss_n = '0;
          end else begin
            miss_n = miss + MW'(1);
          end
        end
      end
      default: st_n = ST_SEARCH;
    endcase
  end

  assign emit = ev && (st_n == ST_LOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_SEARCH;
      off    <= '0;
      hits   <= '0;
      miss   <= '0;
      lock_q <= 1'b0;
    end else begin
      st     <= st_n;
      off    <= off_n;
      hits   <= hits_n;
      miss   <= miss_n;
      lock_q <= (st_n == ST_LOCK);
    end
  end

  assign locked = lock_q;
endmodule

// File: rtl/deser7_rx.sv
// Seven-to-one receive deserializer: gearboxes for every lane, clock-lane
// alignment and the registered parallel output.
module deser7_rx import lvds7_pkg::*; #(
  parameter int LANES      = 4,
  parameter int WORD       = WORD_BITS,
  parameter int LOCK_WORDS = 4,
  parameter int MISS_WORDS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            clk_lane_bits,
  input  logic [2*LANES-1:0]    data_lane_bits,
  output logic [LANES*WORD-1:0] word_out,
  output logic                  word_vld,
  output logic                  locked
);
  localparam int CW    = $clog2(WORD);
  localparam int OUT_W = LANES * WORD;

  logic [CW-1:0]    ncnt, nprev;
  logic [WORD-1:0]  ck_late, ck_early;
  logic             pick_early, emit;
  logic [OUT_W-1:0] word_nxt;

  deser7_phase #(.WORD(WORD)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .ncnt  (ncnt),
    .nprev (nprev)
  );

  deser7_gearbox #(.WORD(WORD)) u_ck_gear (
    .clk         (clk),
    .rst         (rst),
    .pair        (clk_lane_bits),
    .slice_late  (ck_late),
    .slice_early (ck_early)
  );

  deser7_align #(
    .WORD       (WORD),
    .LOCK_WORDS (LOCK_WORDS),
    .MISS_WORDS (MISS_WORDS)
  ) u_align (
    .clk        (clk),
    .rst        (rst),
    .ncnt       (ncnt),
    .nprev      (nprev),
    .clk_late   (ck_late),
    .clk_early  (ck_early),
    .pick_early (pick_early),
    .emit       (emit),
    .locked     (locked)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WORD-1:0] d_late, d_early;

    deser7_gearbox #(.WORD(WORD)) u_gear (
      .clk         (clk),
      .rst         (rst),
      .pair        (data_lane_bits[2*g +: 2]),
      .slice_late  (d_late),
      .slice_early (d_early)
    );

    assign word_nxt[g*WORD +: WORD] = pick_early ? d_early : d_late;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= emit;
      if (emit) word_out <= word_nxt;
    end
  end
endmodule

// File: rtl/deser7_rx_chk.sv
module deser7_rx_chk #(
  parameter int LANES = 4,
  parameter int WORD  = 7
) (
  input logic                  clk,
  input logic                  rst,
  input logic [LANES*WORD-1:0] word_out,
  input logic                  word_vld,
  input logic                  locked
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!locked && !word_vld && (word_out == '0)));

  // R3
  vld_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> locked);

  // R3
  vld_single_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);

  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !word_vld |-> $stable(word_out));

  // R2
  lock_on_word_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> word_vld);

  // R5
  unlock_silent_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> !word_vld);
endmodule

bind deser7_rx deser7_rx_chk #(.LANES(LANES), .WORD(WORD)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .word_out (word_out),
  .word_vld (word_vld),
  .locked   (locked)
);

// File: tb/sim_deser7_rx.sv
module sim_deser7_rx;
  localparam int LANES = 4;
  localparam int W     = 7;
  localparam logic [6:0] SHAPE = 7'b1100011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]         cbits = '0;
  logic [2*LANES-1:0] dbits = '0;
  logic [LANES*W-1:0] word_out;
  logic               word_vld;
  logic               locked;

  always #10 clk = ~clk;

  deser7_rx #(.LANES(LANES)) u0 (
    .clk            (clk),
    .rst            (rst),
    .clk_lane_bits  (cbits),
    .data_lane_bits (dbits),
    .word_out       (word_out),
    .word_vld       (word_vld),
    .locked         (locked)
  );

  typedef struct {
    logic               vld;
    logic               lock;
    logic [LANES*W-1:0] word;
  } exp_t;

  exp_t sbq[$];
  int vectors = 0;
  int errors  = 0;

  int phase;
  int corr[4];
  int m_hits, m_miss;
  bit m_lock;
  logic [LANES*W-1:0] m_word;
  string tag;
  int cyc, last_t, prev_gap;

  function automatic bit is_corrupt(int w);
    for (int k = 0; k < 4; k++) if (corr[k] == w) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [6:0] dword(int lane, int w);
    return 7'((w * 37 + lane * 23 + phase * 11 + 5) % 128);
  endfunction

  // lane < 0 selects the clock lane
  function automatic logic sbit(int lane, int b);
    int pos = (b + phase) % 7;
    int w   = (b + phase) / 7;
    logic [6:0] v;
    if (lane < 0) v = is_corrupt(w) ? 7'd0 : SHAPE;
    else          v = dword(lane, w);
    return v[6 - pos];
  endfunction

  task automatic model_word(int w, output bit out);
    bit hit = !is_corrupt(w);
    if (!m_lock && m_hits == 0) begin
      if (hit) m_hits = 1;
    end else if (!m_lock) begin
      if (hit) begin
        m_hits++;
        if (m_hits == 4) begin m_lock = 1; m_miss = 0; end
      end else m_hits = 0;
    end else begin
      if (hit) m_miss = 0;
      else begin
        m_miss++;
        if (m_miss == 2) begin m_lock = 0; m_hits = 0; m_miss = 0; end
      end
    end
    out = m_lock;
    if (out)
      for (int i = 0; i < LANES; i++) m_word[i*W +: W] = dword(i, w);
  endtask

  // Driver: drive cycle t's pairs and push what is due one edge later
  task automatic drive_cycle(int t);
    exp_t e;
    bit   o;
    int   b0 = 2 * t;
    int   b1 = 2 * t + 1;
    cbits = {sbit(-1, b0), sbit(-1, b1)};
    for (int i = 0; i < LANES; i++) begin
      dbits[2*i+1] = sbit(i, b0);
      dbits[2*i]   = sbit(i, b1);
    end
    e.vld = 1'b0;
    for (int k = 0; k < 2; k++) begin
      int b = b0 + k;
      if ((b + phase) % 7 == 6) begin
        int w = (b + phase) / 7;
        if (7 * w - phase >= 0) begin
          model_word(w, o);
          e.vld = o;
        end
      end
    end
    e.lock = m_lock;
    e.word = m_word;
    sbq.push_back(e);
  endtask

  // Monitor: compare the oldest expectation against the sampled outputs
  task automatic check_cycle();
    exp_t e;
    if (sbq.size() == 0) return;
    e = sbq.pop_front();
    vectors++;
    if (word_vld !== e.vld || locked !== e.lock || word_out !== e.word) begin
      errors++;
      $display("FAIL R2 R3 R4 R6 (%s) cyc=%0d actual vld=%b lock=%b word=%h expected vld=%b lock=%b word=%h",
               tag, cyc, word_vld, locked, word_out, e.vld, e.lock, e.word);
    end
    if (!locked) begin
      last_t = -1; prev_gap = 0;
    end else if (word_vld) begin
      if (last_t >= 0) begin
        int gap = cyc - last_t;
        vectors++;
        if ((prev_gap > 0 && gap != 7 - prev_gap) ||
            (prev_gap == 0 && gap != 3 && gap != 4)) begin
          errors++;
          $display("FAIL R3 cadence (%s) actual gap=%0d expected %0d", tag, gap,
                   (prev_gap > 0) ? 7 - prev_gap : 3);
        end
        prev_gap = gap;
      end
      last_t = cyc;
    end
  endtask

  task automatic run(int ph, int ncyc, string t_tag, int c0, int c1, int c2);
    phase = ph; tag = t_tag;
    corr[0] = c0; corr[1] = c1; corr[2] = c2; corr[3] = -1;
    m_hits = 0; m_miss = 0; m_lock = 0; m_word = '0;
    last_t = -1; prev_gap = 0;
    sbq.delete();
    rst = 1'b1; cbits = '0; dbits = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    vectors++;
    if (locked !== 1'b0 || word_vld !== 1'b0 || word_out !== '0) begin
      errors++;
      $display("FAIL R1 actual lock=%b vld=%b word=%h expected 0 0 0",
               locked, word_vld, word_out);
    end
    rst = 1'b0;
    drive_cycle(0);
    for (int t = 1; t < ncyc; t++) begin
      @(negedge clk);
      cyc = t - 1;
      check_cycle();
      drive_cycle(t);
    end
    @(negedge clk);
    cyc = ncyc - 1;
    check_cycle();
  endtask

  initial begin
    // R7: every boundary offset, plain lock and data (R2, R3, R4)
    for (int p = 0; p < 7; p++) run(p, 50, "R7", -1, -1, -1);
    // R5: single miss keeps lock, double miss drops it, then relock
    run(3, 90, "R5", 8, 14, 15);
    // R8: mismatch while confirming restarts the count
    run(5, 60, "R8", 3, -1, -1);
    // R6: long stretch of no lock after a drop
    run(1, 70, "R6", 6, 7, 11);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (R1) actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule